// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is a full-duplex serial shifter with three pins: a serial clock, a data input and a data output. It holds an 8-bit data register that shifts out MSB first on its data output while the same number of bits are shifted in from its data input. After eight serial clock cycles, two of these units wired output-to-input have swapped their bytes. There is no slave-select pin. Any chip-select handling is left to software.

As master, software makes the serial clock itself. Each control write with the toggle strobe set inverts the clock pin once. As slave, the block follows an external clock. That clock and the data input are passed through a two-flop synchronizer, and their edges are found in the system clock domain. The external clock must therefore run at least four times slower than the system clock. A 4-bit counter advances on every active clock edge, both rising and falling. Sixteen edges wrap it to zero and set a sticky completion flag, which can drive a level interrupt.

Completion is tracked by a three-state machine:
- `ST_IDLE`: the counter is 0 and the flag is clear.
- `ST_XFER`: a transfer is under way.
- `ST_DONE`: the flag is set.

Its transitions are:
- IDLE→XFER on the first active edge.
- XFER→DONE on the edge that wraps the counter.
- DONE→DONE while further edges keep counting.
- Any state→IDLE when software writes 1 to the flag.

Top module: `tws_shifter`

## Requirements
- R1: After reset, the following all read 0: the data register (address 0), control (address 1), status (address 2), `irq`, `sck_out` and `do_out`. Address 3 always reads 0.
- R2: `do_out` always equals bit 7 of the data register. A write to address 0 is visible on `do_out` and in the read-back from the next cycle on.
- R3: Control bit 1 selects the edge roles. With bit 1 = 0, DI is sampled on rising SCK edges and the register shifts on falling edges. With bit 1 = 1, DI is sampled on falling edges and the register shifts on rising edges. Each shift moves the register left by one and puts the last sample into bit 0. The clock idles at the level of bit 1.
- R4: A 16-edge transfer that starts with a sample edge fully exchanges the bytes, MSB first. This holds in master and slave mode and for both edge selections. Afterwards the data register holds the partner's byte, and `do_out` has presented the block's own byte.
- R5: The counter is read at status bits 7:4. It increments on every active SCK edge. The 16th edge from 0 wraps it to 0 and sets the flag (status bit 0).
- R6: The flag stays set until a status write with bit 0 = 1. That write also sets the counter to 0. A status write with bit 0 = 0 changes nothing.
- R7: `irq` is high exactly while the flag is set and control bit 2 (interrupt enable) is 1.
- R8: In master mode (control bit 0 = 1 already in effect), a control write with bit 3 = 1 and bit 0 = 1 inverts `sck_out` once, and that inversion counts as one SCK edge. A control write with bit 3 = 0 sets `sck_out` to the idle level and counts no edge. Bit 3 reads as 0.
- R9: In master mode, `sck_in` has no effect. In slave mode, the toggle strobe has no effect and `sck_out` stays 0. Slave-mode edges are taken from `sck_in` after the synchronizer.
- R10: A data write during a transfer replaces the register at once and leaves the counter unchanged. A clearing write to the flag during a transfer returns the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| sck_in | input | 1 | External serial clock (slave mode) |
| di_in | input | 1 | Serial data input |
| sck_out | output | 1 | Serial clock driven in master mode |
| do_out | output | 1 | Serial data output (register bit 7) |
| irq | output | 1 | Level interrupt: flag and enable |

## Verification
The embedded assertions check several rules on every cycle:
- The counter steps by exactly one per active edge and holds otherwise.
- A wrap sets the flag.
- The flag holds until it is cleared, and clearing zeroes the count.
- A data write loads the register, and the register holds when there is neither a write nor a shift.
- Each honoured strobe inverts `sck_out`, and `sck_out` never moves without a control write.

The full byte exchange in both modes and both edge selections can only be shown by the bench's scenarios. The same applies to the synchronizer latency against a slow external clock, and to the masking of the pin or strobe that the current mode ignores. The bench models the far end of the link for these cases.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_MASTER = 0;
    localparam int CTRL_EDGE   = 1;
    localparam int CTRL_IE     = 2;
    localparam int CTRL_TOGGLE = 3;

    localparam int STAT_FLAG   = 0;

endpackage

// File: rtl/tws_sck_sync.sv
module tws_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic di_raw,
    output logic sck_s,
    output logic di_s,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] di_q;
    logic              sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            di_q  <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_q <= {sck_q[STAGES-2:0], sck_raw};
            di_q  <= {di_q[STAGES-2:0], di_raw};
            sck_d <= sck_q[STAGES-1];
        end
    end

    assign sck_s = sck_q[STAGES-1];
    assign di_s  = di_q[STAGES-1];
    assign rise  = sck_s & ~sck_d;
    assign fall  = ~sck_s & sck_d;

endmodule

// File: rtl/tws_shift_reg.sv
module tws_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sample_en,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] data,
    output logic              dout
);

    logic samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            samp <= 1'b0;
        end else begin
            if (sample_en) begin
                samp <= din;
            end
            if (wr_en) begin
                data <= wdata;
            end else if (shift_en) begin
                data <= {data[DATA_W-2:0], samp};
            end
        end
    end

    assign dout = data[DATA_W-1];

    // R10: a bus write lands in the register regardless of shifting
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data == $past(wdata));

    // R3: register moves only on a write or a shift edge
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !shift_en) |=> $stable(data));

    // R3: the sample latch moves only on a sample edge
    p_samp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(samp));

endmodule

// File: rtl/tws_xfer_ctrl.sv
module tws_xfer_ctrl
    import tws_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_ev,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    xfer_state_e state, state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (!clr && edge_ev) state_n = ST_XFER;
            end
            ST_XFER: begin
                if (clr)                                state_n = ST_IDLE;
                else if (edge_ev && cnt == CNT_LAST)    state_n = ST_DONE;
            end
            ST_DONE: begin
                if (clr) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (edge_ev) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        flag = (state == ST_DONE);
    end

    // R5: one step per active edge
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && !clr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R5: no edge, no count change
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_ev && !clr) |=> $stable(cnt));

    // R5: wrap sets the completion flag
    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && !clr && cnt == CNT_LAST) |=> (flag && cnt == '0));

    // R6: flag is sticky
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R6: clearing drops the flag and zeroes the count
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!flag && cnt == '0));

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter
    import tws_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_in,
    input  logic              di_in,
    output logic              sck_out,
    output logic              do_out,
    output logic              irq
);

    localparam int EDGE_CNT = 2 * DATA_W;
    localparam int CNT_W    = $clog2(EDGE_CNT);

    logic              master_q, edge_sel_q, ie_q, sck_q;
    logic              wr_data, wr_ctrl, wr_stat;
    logic              toggle_req, clr;
    logic              s_sck, s_di, s_rise, s_fall;
    logic              rise, fall, edge_ev, sample_en, shift_en;
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0]  cnt;
    logic              flag;
    logic [DATA_W-1:0] ctrl_rd, stat_rd;

    // bus decode
    assign wr_data    = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat    = bus_wr && (bus_addr == ADDR_STAT);
    assign clr        = wr_stat && bus_wdata[STAT_FLAG];
    assign toggle_req = wr_ctrl && bus_wdata[CTRL_TOGGLE]
                        && bus_wdata[CTRL_MASTER] && master_q;

    // control register and master clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q   <= 1'b0;
            edge_sel_q <= 1'b0;
            ie_q       <= 1'b0;
            sck_q      <= 1'b0;
        end else if (wr_ctrl) begin
            master_q   <= bus_wdata[CTRL_MASTER];
            edge_sel_q <= bus_wdata[CTRL_EDGE];
            ie_q       <= bus_wdata[CTRL_IE];
            if (!bus_wdata[CTRL_MASTER])  sck_q <= 1'b0;
            else if (toggle_req)          sck_q <= ~sck_q;
            else                          sck_q <= bus_wdata[CTRL_EDGE];
        end
    end

    tws_sck_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_raw (sck_in),
        .di_raw  (di_in),
        .sck_s   (s_sck),
        .di_s    (s_di),
        .rise    (s_rise),
        .fall    (s_fall)
    );

    // edge selection per mode
    always_comb begin
        if (master_q) begin
            rise = toggle_req & ~sck_q;
            fall = toggle_req &  sck_q;
        end else begin
            rise = s_rise;
            fall = s_fall;
        end
        edge_ev   = rise | fall;
        sample_en = edge_sel_q ? fall : rise;
        shift_en  = edge_sel_q ? rise : fall;
    end

    tws_shift_reg #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_data),
        .wdata     (bus_wdata),
        .sample_en (sample_en),
        .shift_en  (shift_en),
        .din       (s_di),
        .data      (data),
        .dout      (do_out)
    );

    tws_xfer_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_ev (edge_ev),
        .clr     (clr),
        .cnt     (cnt),
        .flag    (flag)
    );

    // read mux
    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[CTRL_MASTER] = master_q;
        ctrl_rd[CTRL_EDGE]   = edge_sel_q;
        ctrl_rd[CTRL_IE]     = ie_q;
        stat_rd                     = '0;
        stat_rd[STAT_FLAG]          = flag;
        stat_rd[DATA_W-1 -: CNT_W]  = cnt;
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = data;
            ADDR_CTRL: bus_rdata = ctrl_rd;
            ADDR_STAT: bus_rdata = stat_rd;
            default:   bus_rdata = '0;
        endcase
    end

    assign sck_out = sck_q;
    assign irq     = flag & ie_q;

    // R8: every honoured strobe inverts the clock pin
    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_req |=> sck_out != $past(sck_out));

    // R9: the clock pin never moves without a control write
    p_sck_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(sck_out));

    // R3: an edge is never both rising and falling
    p_one_role_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en && shift_en));

endmodule

// File: tb/tws_shifter_tb.sv
module tws_shifter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_in = 1'b0;
    logic       di_in = 1'b0;
    logic       sck_out, do_out, irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tws_shifter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck_in    (sck_in),
        .di_in     (di_in),
        .sck_out   (sck_out),
        .do_out    (do_out),
        .irq       (irq)
    );

    // {master, edge_sel, ie, dut_byte, partner_byte}
    localparam logic [18:0] VEC [0:5] = '{
        {1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C},
        {1'b1, 1'b1, 1'b0, 8'h81, 8'h7E},
        {1'b0, 1'b0, 1'b1, 8'h5A, 8'hC3},
        {1'b0, 1'b1, 1'b1, 8'hF0, 8'h0F},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'hFF},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h01}
    };

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sck_edge(input logic master, input logic sel, input logic ie);
        if (master) wr(2'd1, {4'b0000, 1'b1, ie, sel, 1'b1});
        else begin
            @(negedge clk);
            sck_in = ~sck_in;
        end
        idle(8);
    endtask

    task automatic run_xfer(input logic master, input logic sel, input logic ie,
                            input logic [7:0] dut_b, input logic [7:0] ext_b,
                            output logic [7:0] got);
        logic [7:0] ext_sr;
        if (master) begin
            wr(2'd1, {5'b00000, ie, sel, 1'b1});
        end else begin
            @(negedge clk);
            sck_in = sel;
            wr(2'd1, {5'b00000, ie, sel, 1'b0});
        end
        idle(8);
        wr(2'd2, 8'h01);
        wr(2'd0, dut_b);
        ext_sr = ext_b;
        di_in  = ext_sr[7];
        idle(4);
        got = 8'h00;
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) begin
                @(negedge clk);
                got = {got[6:0], do_out};
                sck_edge(master, sel, ie);
            end else begin
                sck_edge(master, sel, ie);
                ext_sr = {ext_sr[6:0], 1'b0};
                di_in  = ext_sr[7];
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, got;
        idle(3);
        // R1 reset state
        rd(2'd0, v); chk("R1 data", v, 8'h00);
        rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd2, v); chk("R1 stat", v, 8'h00);
        chk("R1 pins", {5'b0, irq, sck_out, do_out}, 8'h00);
        rst_n = 1'b1;
        idle(2);
        rd(2'd3, v); chk("R1 addr3", v, 8'h00);

        // R2 do_out follows bit 7 right after a write
        wr(2'd0, 8'h80); chk("R2 do high", {7'b0, do_out}, 8'h01);
        rd(2'd0, v);     chk("R2 readback", v, 8'h80);
        wr(2'd0, 8'h7F); chk("R2 do low", {7'b0, do_out}, 8'h00);

        // R4 R5 R6 R7 vector table
        for (int k = 0; k < 6; k++) begin
            logic m, s, e;
            logic [7:0] db, eb;
            {m, s, e, db, eb} = VEC[k];
            run_xfer(m, s, e, db, eb, got);
            rd(2'd0, v); chk("R4 dut received", v, eb);
            chk("R4 partner received", got, db);
            rd(2'd2, v); chk("R5 wrap sets flag", v, 8'h01);
            chk("R7 irq", {7'b0, irq}, {7'b0, e});
            if (m) chk("R3 idle level", {7'b0, sck_out}, {7'b0, s});
            wr(2'd2, 8'h00);
            rd(2'd2, v); chk("R6 write 0 keeps flag", v, 8'h01);
            wr(2'd2, 8'h01);
            rd(2'd2, v); chk("R6 clear", v, 8'h00);
            chk("R7 irq after clear", {7'b0, irq}, 8'h00);
        end

        // R8 strobe toggles once per write
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h01);
        chk("R8 idle low", {7'b0, sck_out}, 8'h00);
        wr(2'd1, 8'h09); chk("R8 toggle up", {7'b0, sck_out}, 8'h01);
        wr(2'd1, 8'h09); chk("R8 toggle down", {7'b0, sck_out}, 8'h00);
        rd(2'd1, v); chk("R8 strobe reads 0", v, 8'h01);
        rd(2'd2, v); chk("R8 two edges counted", v, 8'h20);
        wr(2'd1, 8'h03); chk("R8 idle reload", {7'b0, sck_out}, 8'h01);
        rd(2'd2, v); chk("R8 reload no edge", v, 8'h20);
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h01);

        // R9 sck_in ignored in master mode
        for (int j = 0; j < 4; j++) begin
            @(negedge clk); sck_in = ~sck_in; idle(6);
        end
        rd(2'd2, v); chk("R9 master ignores sck_in", v, 8'h00);
        // R9 strobe ignored in slave mode
        wr(2'd1, 8'h00);
        idle(6);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h08);
        idle(4);
        chk("R9 slave sck_out", {7'b0, sck_out}, 8'h00);
        rd(2'd2, v); chk("R9 slave ignores strobe", v, 8'h00);

        // R10 mid-transfer data write and clear
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hA5);
        for (int j = 0; j < 5; j++) wr(2'd1, 8'h09);
        rd(2'd2, v); chk("R10 count 5", v, 8'h50);
        wr(2'd0, 8'h3C);
        rd(2'd0, v); chk("R10 write wins", v, 8'h3C);
        rd(2'd2, v); chk("R10 count kept", v, 8'h50);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R10 clear zeroes count", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule